// File: doc/BRIEF.md
# Serial-Bus Byte Memory Target with Page Write Buffer

This block is the target side of a two-wire serial memory. SCL and SDA are sampled with the system clock through short synchronisers. SDA is driven open-drain through a single output enable, which pulls the line low when high. Behind the bus logic sits a small byte array with a power-of-two depth.

A controller addresses the block with a 7-bit device identifier plus a direction bit, then gives a one-byte word address. In the write direction it then sends data. In the read direction the block streams bytes out of the array starting at the current address.

Write data is gathered in a page buffer and reaches the array only when a STOP closes the transaction. That commit starts a timed programming window. During the window the block ignores its own identifier. A write-protect input held high turns the whole array read-only.

Top module: `i2c_page_mem`

## Requirements
- R1: After reset the SDA enable is low, every array byte reads 0xFF, and the block acknowledges its identifier at once (no programming window is running).
- R2: The block acknowledges by pulling SDA low during the ninth clock. It does so only when bits 7..1 of the first byte after START equal `DEV_ID`. On any other identifier it stays released until the next START.
- R3: In a write transaction (direction bit 0), the word-address byte and every data byte are acknowledged. Data bytes are held in the page buffer and written to the array only at STOP. A repeated START discards them.
- R4: During a page write the low log2(`PAGE_BYTES`) address bits wrap within the page and the upper bits stay fixed. A byte sent past the page end overwrites the earlier byte at that offset.
- R5: A STOP that commits at least one byte starts a window of `PROG_CYCLES` clock cycles. During the window the identifier is not acknowledged and SDA is never driven. After the window the identifier is acknowledged again.
- R6: With the write-protect input high at STOP, address and data bytes are still acknowledged, but no array byte changes and no programming window starts.
- R7: A write of the word address, a repeated START and the identifier with direction bit 1 returns the byte stored at that address, most-significant bit first.
- R8: In a read, each controller acknowledge advances the address by one across the whole array, and the address wraps from the top byte to address 0.
- R9: After the controller answers a read byte with NACK (SDA high on the ninth clock), the block releases SDA and drives it no further; a STOP keeps it released.
- R10: A START in the middle of a byte abandons that byte and restarts identifier reception.
- R11: The SDA enable rises only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| wp_i | input | 1 | Write protect; high makes the array read-only |
| sda_oe_o | output | 1 | High pulls SDA low; low releases it |

## Verification
The hardest condition to reach from the ports is the programming window. The bench has to start a new transaction within `PROG_CYCLES` of the committing STOP and see the identifier go unacknowledged. It must then wait the window out and see the acknowledge return. The bench shortens `PROG_CYCLES` and issues the START straight after the write's STOP. This places the ninth identifier clock well inside the window. The page-wrap case is reached by starting an 18-byte write two bytes before a page end. The readback runs one byte past the page to show that the next page stayed untouched.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WADDR,
      ST_WDATA,
      ST_ACK,
      ST_RDATA,
      ST_RACK
   } slv_state_e;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
   parameter int   STAGES = 2,
   parameter logic INIT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("i2cm_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) q <= INIT;
         else        q <= d_i;
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) q <= {STAGES{INIT}};
         else        q <= {q[STAGES-2:0], d_i};
   end

   assign q_o = q[STAGES-1];
endmodule

// File: rtl/i2cm_bus_cond.sv
module i2cm_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s & scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s & scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2cm_page_buf.sv
module i2cm_page_buf #(
   parameter int  BYTES = 16,
   localparam int IW    = $clog2(BYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr_i,
   input  logic                  we_i,
   input  logic [IW-1:0]         idx_i,
   input  logic [7:0]            wdata_i,
   output logic [BYTES-1:0][7:0] data_o,
   output logic [BYTES-1:0]      vld_o
);
   if ((1 << IW) != BYTES || BYTES < 2) begin : g_bad_bytes
      $error("i2cm_page_buf: BYTES must be a power of two of at least 2");
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         data_o <= '0;
         vld_o  <= '0;
      end else if (clr_i) begin
         vld_o  <= '0;
      end else if (we_i) begin
         data_o[idx_i] <= wdata_i;
         vld_o[idx_i]  <= 1'b1;
      end
endmodule

// File: rtl/i2cm_prog_timer.sv
module i2cm_prog_timer #(
   parameter int  CYCLES = 500000,
   localparam int CW     = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   if (CYCLES < 1) begin : g_bad_cycles
      $error("i2cm_prog_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)             cnt <= '0;
      else if (start_i)       cnt <= CW'(CYCLES);
      else if (cnt != '0)     cnt <= cnt - 1'b1;

   assign busy_o = (cnt != '0);
endmodule

// File: rtl/i2c_page_mem.sv
module i2c_page_mem
   import i2cm_pkg::*;
#(
   parameter logic [6:0] DEV_ID      = 7'h50,
   parameter int         ADDR_W      = 8,
   parameter int         PAGE_BYTES  = 16,
   parameter int         PROG_CYCLES = 500000,
   parameter int         SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic wp_i,
   output logic sda_oe_o
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int OFF_W = $clog2(PAGE_BYTES);

   if (ADDR_W > 8 || ADDR_W <= OFF_W) begin : g_bad_addr
      $error("i2c_page_mem: ADDR_W must exceed the page offset width and fit one byte");
   end

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;
   logic busy, commit, pb_we;
   logic [PAGE_BYTES-1:0][7:0] pb_data;
   logic [PAGE_BYTES-1:0]      pb_vld;

   slv_state_e        state, nxt;
   logic [3:0]        bitcnt;
   logic [7:0]        shreg;
   logic [ADDR_W-1:0] addr;
   logic              mack;
   logic [7:0]        mem [DEPTH];

   i2cm_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
   i2cm_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   i2cm_bus_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   // a completed data byte lands in the page slot picked by the low address bits
   assign pb_we  = (state == ST_WDATA) && scl_fall && (bitcnt == 4'd8)
                   && !start_det && !stop_det;
   assign commit = stop_det && (|pb_vld) && !wp_i && !busy;

   i2cm_page_buf #(.BYTES(PAGE_BYTES)) u_page (
      .clk(clk), .rst_n(rst_n), .clr_i(start_det | stop_det),
      .we_i(pb_we), .idx_i(addr[OFF_W-1:0]), .wdata_i(shreg),
      .data_o(pb_data), .vld_o(pb_vld));

   i2cm_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_i(commit), .busy_o(busy));

   // protocol engine
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state    <= ST_IDLE;
         nxt      <= ST_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         addr     <= '0;
         mack     <= 1'b0;
         sda_oe_o <= 1'b0;
      end else if (start_det) begin
         state    <= ST_DEV;
         bitcnt   <= '0;
         sda_oe_o <= 1'b0;
      end else if (stop_det) begin
         state    <= ST_IDLE;
         sda_oe_o <= 1'b0;
      end else begin
         unique case (state)
            ST_DEV, ST_WADDR, ST_WDATA: begin
               if (scl_rise) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (scl_fall && bitcnt == 4'd8) begin
                  bitcnt <= '0;
                  if (state == ST_DEV) begin
                     if (shreg[7:1] == DEV_ID && !busy) begin
                        sda_oe_o <= 1'b1;
                        state    <= ST_ACK;
                        nxt      <= shreg[0] ? ST_RDATA : ST_WADDR;
                     end else begin
                        state    <= ST_IDLE;
                     end
                  end else begin
                     if (state == ST_WADDR)
                        addr <= shreg[ADDR_W-1:0];
                     else
                        addr <= {addr[ADDR_W-1:OFF_W], addr[OFF_W-1:0] + OFF_W'(1)};
                     sda_oe_o <= 1'b1;
                     state    <= ST_ACK;
                     nxt      <= ST_WDATA;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  sda_oe_o <= 1'b0;
                  bitcnt   <= '0;
                  state    <= nxt;
                  if (nxt == ST_RDATA) begin
                     shreg    <= mem[addr];
                     sda_oe_o <= ~mem[addr][7];
                     addr     <= addr + 1'b1;
                  end
               end
            end
            ST_RDATA: begin
               if (scl_fall) begin
                  if (bitcnt == 4'd7) begin
                     sda_oe_o <= 1'b0;
                     bitcnt   <= '0;
                     state    <= ST_RACK;
                  end else begin
                     bitcnt   <= bitcnt + 4'd1;
                     shreg    <= {shreg[6:0], 1'b0};
                     sda_oe_o <= ~shreg[6];
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  mack <= ~sda_s;
               end else if (scl_fall) begin
                  if (mack) begin
                     shreg    <= mem[addr];
                     sda_oe_o <= ~mem[addr][7];
                     addr     <= addr + 1'b1;
                     state    <= ST_RDATA;
                  end else begin
                     state    <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end

   // byte array: every buffered slot is committed into the current page
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (commit) begin
         for (int j = 0; j < PAGE_BYTES; j++)
            if (pb_vld[j])
               mem[{addr[ADDR_W-1:OFF_W], OFF_W'(j)}] <= pb_data[j];
      end
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic stop_det,
   input logic wp_i,
   input logic busy,
   input logic sda_oe_o
);
   // R11: the enable only rises in a low phase of the sampled clock
   a_r11_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !$past(scl_s));

   // R5: nothing is driven while the programming window runs
   a_r5_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe_o);

   // R5: a programming window only ever opens on a STOP
   a_r5_prog_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_det));

   // R6: a protected STOP never opens a programming window
   a_r6_wp_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(wp_i));

   // R9: SDA is released after every STOP
   a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe_o);
endmodule

bind i2c_page_mem i2cm_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
   .wp_i(wp_i), .busy(busy), .sda_oe_o(sda_oe_o));

// File: tb/i2c_page_mem_tb.sv
module i2c_page_mem_tb;
   localparam int         PROG = 400;
   localparam logic [6:0] DEV  = 7'h50;
   localparam int         H    = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
   logic sda_oe;
   wire  sda_line = sda_m & ~sda_oe;

   int nchk = 0, nerr = 0;
   logic [7:0] ref_mem [256];
   logic [7:0] wbuf [32];
   logic [7:0] rbuf [32];
   logic       oe_after_nack;

   always #10 clk = ~clk;

   i2c_page_mem #(.DEV_ID(DEV), .PROG_CYCLES(PROG)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .wp_i(wp), .sda_oe_o(sda_oe));

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int got, input int exp);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H);
      sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(H/2);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H);
      sda_m = 1'b1; wt(H);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(H/2);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H/2);
      ack = (sda_line == 1'b0);
      wt(H/2); scl_m = 1'b0; wt(H/2);
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      sda_m = 1'b1;
      for (int i = 0; i < 8; i++) begin
         wt(H); scl_m = 1'b1; wt(H/2);
         d = {d[6:0], sda_line};
         wt(H/2); scl_m = 1'b0; wt(H/2);
      end
      sda_m = ~give_ack; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(H/2);
      sda_m = 1'b1;
   endtask

   task automatic wr_txn(input logic [7:0] a, input int n, output int acks);
      logic k;
      acks = 0;
      i2c_start();
      send_byte({DEV, 1'b0}, k); acks += int'(k);
      send_byte(a, k);           acks += int'(k);
      for (int i = 0; i < n; i++) begin send_byte(wbuf[i], k); acks += int'(k); end
      i2c_stop();
      if (!wp && n > 0)
         for (int i = 0; i < n; i++) ref_mem[{a[7:4], 4'(a[3:0] + i)}] = wbuf[i];
   endtask

   task automatic rd_txn(input logic [7:0] a, input int n, output int acks);
      logic k;
      acks = 0;
      i2c_start();
      send_byte({DEV, 1'b0}, k); acks += int'(k);
      send_byte(a, k);           acks += int'(k);
      i2c_start();
      send_byte({DEV, 1'b1}, k); acks += int'(k);
      for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
      wt(2);
      oe_after_nack = sda_oe;
      i2c_stop();
   endtask

   task automatic check_read(input string req, input logic [7:0] a, input int n);
      int acks;
      rd_txn(a, n, acks);
      chk({req, " read acks"}, acks, 3);
      for (int i = 0; i < n; i++) chk(req, rbuf[i], ref_mem[8'(a + i)]);
   endtask

   task automatic t_reset();
      chk("R1 enable low after reset", sda_oe, 0);
      check_read("R1 erased array", 8'h00, 2);
      check_read("R1 erased top byte", 8'hFF, 1);
   endtask

   task automatic t_page_write();
      int acks; logic k;
      wbuf[0] = 8'h81; wbuf[1] = 8'h3C; wbuf[2] = 8'hA5; wbuf[3] = 8'h07;
      wr_txn(8'h23, 4, acks);
      chk("R3 write acks", acks, 6);
      i2c_start();
      send_byte({DEV, 1'b0}, k);
      chk("R5 identifier NACKed while programming", int'(k), 0);
      chk("R5 enable low while programming", sda_oe, 0);
      i2c_stop();
      wt(PROG + 40);
      check_read("R7 random read after page write", 8'h23, 4);
   endtask

   task automatic t_discard();
      logic k;
      i2c_start();
      send_byte({DEV, 1'b0}, k); send_byte(8'h40, k);
      send_byte(8'hAA, k); send_byte(8'hBB, k);
      i2c_start();
      send_byte({DEV, 1'b1}, k);
      chk("R3 identifier acked after repeated START (no window)", int'(k), 1);
      recv_byte(1'b0, rbuf[0]);
      i2c_stop();
      check_read("R3 repeated START discards buffered bytes", 8'h40, 2);
   endtask

   task automatic t_wrap();
      int acks;
      for (int i = 0; i < 18; i++) wbuf[i] = 8'(8'h10 + 3 * i);
      wr_txn(8'h5E, 18, acks);
      chk("R4 page write acks", acks, 20);
      wt(PROG + 40);
      check_read("R4 page wrap and untouched next page", 8'h50, 17);
   endtask

   task automatic t_wp();
      int acks; logic k;
      wp = 1'b1;
      wbuf[0] = 8'h11; wbuf[1] = 8'h22;
      wr_txn(8'h23, 2, acks);
      chk("R6 protected write still acked", acks, 4);
      i2c_start();
      send_byte({DEV, 1'b0}, k);
      chk("R6 no programming window after protected STOP", int'(k), 1);
      i2c_stop();
      check_read("R6 protected bytes unchanged", 8'h23, 2);
      wp = 1'b0;
   endtask

   task automatic t_seq_wrap();
      int acks;
      wbuf[0] = 8'h5A;
      wr_txn(8'h00, 1, acks);
      wt(PROG + 40);
      wbuf[0] = 8'hC3; wbuf[1] = 8'h96;
      wr_txn(8'hFE, 2, acks);
      wt(PROG + 40);
      check_read("R8 sequential read wraps to address 0", 8'hFE, 3);
   endtask

   task automatic t_wrong_id();
      logic k;
      i2c_start();
      send_byte({7'h52, 1'b0}, k);
      chk("R2 foreign identifier not acked", int'(k), 0);
      send_byte(8'h23, k);
      chk("R2 silent for rest of foreign transfer", int'(k), 0);
      i2c_stop();
   endtask

   task automatic t_abort();
      logic k;
      i2c_start();
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      i2c_start();
      send_byte({DEV, 1'b0}, k);
      chk("R10 START mid-byte restarts identifier", int'(k), 1);
      send_byte(8'h23, k);
      chk("R10 word address acked after restart", int'(k), 1);
      i2c_stop();
   endtask

   task automatic t_nack();
      int acks;
      rd_txn(8'h23, 1, acks);
      chk("R9 released after controller NACK", oe_after_nack, 0);
      chk("R9 released after STOP", sda_oe, 0);
      chk("R9 bus line high after STOP", sda_line, 1);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
      wt(5);
      rst_n = 1'b1;
      wt(5);
      t_reset();
      t_page_write();
      t_discard();
      t_wrap();
      t_wp();
      t_seq_wrap();
      t_wrong_id();
      t_abort();
      t_nack();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule